// File: doc/BRIEF.md
# Byte-Lane Banked 16-Bit SRAM Module

This block is a 16-bit-wide static memory that a 16-bit processor bus can access as a full word or as a single byte. The storage is four byte-wide arrays arranged as two pairs. In each pair, one array serves the even-address byte lane on data bits 7:0 and the other serves the odd-address byte lane on data bits 15:8. The top address bit chooses the pair. The address bits between bit 0 and that top bit form the word index, and every array receives the same word index.

The bus drives a byte address, an active-low read strobe, an active-low write strobe, an active-low high-byte enable and a write word. The block decodes these inputs into one active-low chip select and one active-low write enable per array. It returns read data on a separate 16-bit bus, and the read path is combinational.

On a write, only the byte lanes named by the high-byte enable and address bit 0 are selected. On a read, both arrays of the addressed pair are selected, and the processor takes whichever byte it needs. The arrays are written on the clock edge. Placing the block in the processor's address map and adding wait states are handled outside it.

Top module: `banked_sram16`

## Requirements
- R1: On a write, the lanes follow the pair (bhe_n, addr[0]): (0,0) selects both lanes; (0,1) selects only the high lane; (1,0) selects only the low lane; (1,1) selects no lane. cs_n is asserted only for the selected lanes.
- R2: addr[ADDR_W-1]=0 addresses the lower pair, chips 0 (low lane) and 1 (high lane). addr[ADDR_W-1]=1 addresses the upper pair, chips 2 (low lane) and 3 (high lane). No chip of the other pair is ever selected.
- R3: On a read (rd_n=0, wr_n=1), both chips of the addressed pair have cs_n low, whatever the values of bhe_n and addr[0].
- R4: When rd_n and wr_n are both low, or both high, all cs_n and we_n bits are high, rdata is zero and no array changes.
- R5: During a write, we_n is low for both chips of the addressed pair. An array is written only when its cs_n and its we_n are both low, so a lane whose cs_n stays high keeps its old byte.
- R6: The low lane always takes wdata[7:0]. The high lane always takes wdata[15:8], including on a high-lane-only write to an odd address.
- R7: Every array uses addr[ADDR_W-2:1] as its word index. Bytes at byte addresses 2k and 2k+1 of the same pair share word k.
- R8: During a read, rdata[7:0] returns the low-lane array and rdata[15:8] returns the high-lane array of the addressed pair, in the same cycle.
- R9: Whenever no read is active, rdata is zero.
- R10: While rst_n is low, all cs_n and we_n bits are high and no write takes effect.
- R11: A write with bhe_n=1 and addr[0]=1 changes no array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the arrays are written on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; blocks every chip while low |
| addr | input | ADDR_W | Byte address; the top bit picks the pair, bit 0 picks the even or odd byte |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| bhe_n | input | 1 | Active-low high-byte lane enable |
| wdata | input | 16 | Write word; bits 7:0 go to the low lane, bits 15:8 to the high lane |
| rdata | output | 16 | Read word from the addressed pair; zero when no read is active |
| cs_n | output | 4 | Active-low chip selects, one per array (index = 2*pair + lane) |
| we_n | output | 4 | Active-low write enables, one per array |

## Verification
The hardest thing to see from the ports is whether a byte write leaves its partner lane alone. A read always returns both lanes, so a wrong lane decode only shows up if the partner byte already holds a known value that differs from the new data. The bench therefore first fills every word of both pairs with distinct patterns. It then sweeps every byte address with both settings of the high-byte enable, which covers the low-only, high-only, word and no-lane cases on even and odd addresses. After each sweep it reads back every word in full and compares it with a byte-addressed model that is updated only for the lanes the decode table selects.

// File: rtl/sram16_pkg.sv
// Package: shared types and lane/pair helpers for the banked 16-bit memory.
// Assumes two byte lanes per pair and two pairs; chip index = 2*pair + lane.
package sram16_pkg;

    localparam int LANES      = 2;
    localparam int PAIRS      = 2;
    localparam int CHIPS      = LANES * PAIRS;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = BYTE_W * LANES;

    // Decoded bus operation after strobe qualification.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } bus_op_t;

    // Lane served by a chip: 0 = even/low byte, 1 = odd/high byte.
    function automatic int lane_of(input int chip);
        return chip % LANES;
    endfunction

    // Pair a chip belongs to.
    function automatic int pair_of(input int chip);
        return chip / LANES;
    endfunction

endpackage

// File: rtl/sram16_strobe_decode.sv
// Module: sram16_strobe_decode
// Turns the bus strobes into per-chip active-low select and write enable.
// Writes select only the lanes named by (bhe_n, a0); reads select both chips
// of the addressed pair. Equal strobes or reset give an idle bus.
// Assumes the strobes are already synchronous to clk.
module sram16_strobe_decode
    import sram16_pkg::*;
(
    input  logic             rst_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             bhe_n,
    input  logic             a0,
    input  logic             pair_sel,
    output bus_op_t          op,
    output logic [CHIPS-1:0] cs_n,
    output logic [CHIPS-1:0] we_n
);

    logic lo_want;
    logic hi_want;

    // Qualify the strobes: exactly one active strobe outside reset is an access.
    always_comb begin
        if (!rst_n) begin
            op = OP_IDLE;
        end else begin
            case ({rd_n, wr_n})
                2'b01:   op = OP_READ;
                2'b10:   op = OP_WRITE;
                default: op = OP_IDLE;
            endcase
        end
    end

    // Lane requests from the byte enable pair.
    always_comb begin
        lo_want = ~a0;
        hi_want = ~bhe_n;
    end

    for (genvar c = 0; c < CHIPS; c++) begin : g_chip
        localparam int   LANE = lane_of(c);
        localparam logic PAIR = (pair_of(c) != 0);

        logic in_pair;
        logic lane_ok;

        // Per-chip select and write enable for this array.
        always_comb begin
            in_pair = (pair_sel == PAIR);
            lane_ok = (LANE != 0) ? hi_want : lo_want;
            cs_n[c] = ~(in_pair && ((op == OP_READ) ||
                                    ((op == OP_WRITE) && lane_ok)));
            we_n[c] = ~(in_pair && (op == OP_WRITE));
        end
    end

endmodule

// File: rtl/sram16_byte_array.sv
// Module: sram16_byte_array
// One byte-wide static array: synchronous write when both cs_n and we_n are
// low, combinational read. The output is zero while the chip is deselected,
// which stands in for a released data bus.
// Assumes the contents are not reset.
module sram16_byte_array #(
    parameter int WORD_AW = 8,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               cs_n,
    input  logic               we_n,
    input  logic [WORD_AW-1:0] word_addr,
    input  logic [DATA_W-1:0]  din,
    output logic [DATA_W-1:0]  dout
);

    localparam int DEPTH = 1 << WORD_AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              do_write;

    // Write strobe needs both chip select and write enable.
    always_comb begin
        do_write = ~cs_n & ~we_n;
    end

    // Store a byte on the rising edge.
    always_ff @(posedge clk) begin
        if (do_write) begin
            mem[word_addr] <= din;
        end
    end

    // Drive the stored byte only while selected for a read.
    always_comb begin
        if (!cs_n && we_n) begin
            dout = mem[word_addr];
        end else begin
            dout = '0;
        end
    end

endmodule

// File: rtl/sram16_read_merge.sv
// Module: sram16_read_merge
// Builds the 16-bit read word: each lane ORs the outputs of the arrays
// on that lane (deselected arrays give zero), and the word is zero when no
// read is active.
// Assumes at most one array per lane drives non-zero data at a time.
module sram16_read_merge
    import sram16_pkg::*;
(
    input  logic              read_act,
    input  logic [BYTE_W-1:0] chip_dout [CHIPS],
    output logic [WORD_W-1:0] rdata
);

    logic [BYTE_W-1:0] lane_or [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // OR together every array that sits on lane l.
        always_comb begin
            lane_or[l] = '0;
            for (int c = 0; c < CHIPS; c++) begin
                if (lane_of(c) == l) begin
                    lane_or[l] = lane_or[l] | chip_dout[c];
                end
            end
        end

        // Place the lane on its bus bits, gated by read activity.
        always_comb begin
            rdata[l*BYTE_W +: BYTE_W] = read_act ? lane_or[l] : '0;
        end
    end

endmodule

// File: rtl/banked_sram16.sv
// Module: banked_sram16 (top)
// 16-bit memory built from four byte arrays in two pairs, accessible as a
// word or a byte. Top address bit picks the pair, bit 0 and bhe_n pick lanes.
// Assumes the bus never changes addr while a write strobe spans a clock edge.
module banked_sram16
    import sram16_pkg::*;
#(
    parameter int ARRAY_AW = 8,
    localparam int ADDR_W  = ARRAY_AW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              bhe_n,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic [3:0]        cs_n,
    output logic [3:0]        we_n
);

    bus_op_t             op;
    logic [ARRAY_AW-1:0] word_idx;
    logic                pair_sel;
    logic                read_act;
    logic [BYTE_W-1:0]   chip_dout [CHIPS];

    // Split the byte address into pair, word index and byte select.
    always_comb begin
        pair_sel = addr[ADDR_W-1];
        word_idx = addr[ADDR_W-2:1];
        read_act = (op == OP_READ);
    end

    sram16_strobe_decode u_decode (
        .rst_n    (rst_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .bhe_n    (bhe_n),
        .a0       (addr[0]),
        .pair_sel (pair_sel),
        .op       (op),
        .cs_n     (cs_n),
        .we_n     (we_n)
    );

    for (genvar c = 0; c < CHIPS; c++) begin : g_array
        localparam int LANE = lane_of(c);

        sram16_byte_array #(
            .WORD_AW (ARRAY_AW),
            .DATA_W  (BYTE_W)
        ) u_array (
            .clk       (clk),
            .cs_n      (cs_n[c]),
            .we_n      (we_n[c]),
            .word_addr (word_idx),
            .din       (wdata[LANE*BYTE_W +: BYTE_W]),
            .dout      (chip_dout[c])
        );
    end

    sram16_read_merge u_merge (
        .read_act  (read_act),
        .chip_dout (chip_dout),
        .rdata     (rdata)
    );

endmodule

// File: rtl/banked_sram16_chk.sv
// Module: banked_sram16_chk
// Port-level protocol checks for banked_sram16, attached by bind.
// Assumes the bound instance's own port names.
module banked_sram16_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_n,
    input logic              wr_n,
    input logic              bhe_n,
    input logic [15:0]       rdata,
    input logic [3:0]        cs_n,
    input logic [3:0]        we_n
);

    assert_idle_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n == wr_n) |-> ((cs_n == 4'hF) && (we_n == 4'hF) && (rdata == 16'h0)));

    assert_read_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && wr_n) |-> (cs_n == (addr[ADDR_W-1] ? 4'b0011 : 4'b1100)));

    assert_write_lane_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && rd_n) |->
        ($countones(~cs_n) == (32'(!bhe_n) + 32'(!addr[0]))));

    assert_pair_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(((!cs_n[0]) || (!cs_n[1])) && ((!cs_n[2]) || (!cs_n[3]))));

    assert_we_only_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n && rd_n) |-> (we_n == 4'hF));

    assert_rdata_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> (rdata == 16'h0));

    assert_no_lane_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && rd_n && bhe_n && addr[0]) |-> (cs_n == 4'hF));

endmodule

bind banked_sram16 banked_sram16_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .bhe_n (bhe_n),
    .rdata (rdata),
    .cs_n  (cs_n),
    .we_n  (we_n)
);

// File: tb/tb_banked_sram16.sv
`timescale 1ns/1ps
// Bench: exhaustive byte/word sweep over a 64-byte configuration against a
// byte-addressed model.
module tb_banked_sram16;

    localparam int AAW = 4;
    localparam int AW  = AAW + 2;
    localparam int NB  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          rd_n, wr_n, bhe_n;
    logic [15:0]   wdata;
    logic [15:0]   rdata;
    logic [3:0]    cs_n, we_n;

    logic [7:0] model [NB];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    banked_sram16 #(.ARRAY_AW(AAW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
        .bhe_n(bhe_n), .wdata(wdata), .rdata(rdata), .cs_n(cs_n), .we_n(we_n)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_wr_cs(input logic [AW-1:0] a, input logic bhe);
        logic [3:0] v = 4'hF;
        int base = a[AW-1] ? 2 : 0;
        if (!a[0]) v[base]   = 1'b0;
        if (!bhe)  v[base+1] = 1'b0;
        return v;
    endfunction

    function automatic logic [3:0] pair_low(input logic [AW-1:0] a);
        return a[AW-1] ? 4'b0011 : 4'b1100;
    endfunction

    task automatic idle();
        rd_n = 1'b1; wr_n = 1'b1; bhe_n = 1'b1; wdata = 16'h0;
    endtask

    // Write with strobe check; model updated per the lane table.
    task automatic do_write(input logic [AW-1:0] a, input logic bhe, input logic [15:0] d);
        int base = int'(a) & ~1;
        @(negedge clk);
        addr = a; bhe_n = bhe; wdata = d; wr_n = 1'b0; rd_n = 1'b1;
        #1;
        check((!a[0] || !bhe) ? "R1" : "R11", "cs_n on write", {12'h0, cs_n}, {12'h0, exp_wr_cs(a, bhe)});
        check("R5", "we_n on write", {12'h0, we_n}, {12'h0, pair_low(a)});
        check("R9", "rdata during write", rdata, 16'h0);
        if (!a[0]) model[base]   = d[7:0];
        if (!bhe)  model[base+1] = d[15:8];
        @(negedge clk);
        idle();
    endtask

    // Read a word and compare both lanes against the model.
    task automatic do_read(input logic [AW-1:0] a, input logic bhe);
        int base = int'(a) & ~1;
        @(negedge clk);
        addr = a; bhe_n = bhe; rd_n = 1'b0; wr_n = 1'b1;
        #1;
        check("R3", "cs_n on read", {12'h0, cs_n}, {12'h0, pair_low(a)});
        check("R8", "rdata word", rdata, {model[base+1], model[base]});
        @(negedge clk);
        idle();
        #1;
        check("R9", "rdata idle", rdata, 16'h0);
    endtask

    task automatic read_all();
        for (int w = 0; w < NB; w += 2) do_read(AW'(w), 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; addr = '0; idle();
        repeat (3) @(negedge clk);
        #1;
        check("R10", "cs_n in reset", {12'h0, cs_n}, 16'h000F);
        check("R10", "we_n in reset", {12'h0, we_n}, 16'h000F);
        rst_n = 1'b1;

        // Fill every word of both pairs with distinct patterns (R2, R7).
        for (int w = 0; w < NB; w += 2)
            do_write(AW'(w), 1'b0, {8'(w * 5 + 3), 8'(w ^ 8'hA5)});
        read_all();

        // Byte/word sweep: every address with both bhe_n values (R1, R6, R11).
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < NB; a++)
                do_write(AW'(a), m[0], {8'(a * 7 + m + 17), 8'(~a - m)});
            read_all();
        end

        // Reads ignore the byte enables: odd address with bhe_n high (R3).
        do_read(AW'(NB - 1), 1'b1);
        do_read(AW'(1), 1'b1);

        // Both strobes low: nothing selected, nothing written (R4).
        @(negedge clk);
        addr = AW'(4); bhe_n = 1'b0; wdata = 16'hDEAD; rd_n = 1'b0; wr_n = 1'b0;
        #1;
        check("R4", "cs_n both strobes", {12'h0, cs_n}, 16'h000F);
        check("R4", "we_n both strobes", {12'h0, we_n}, 16'h000F);
        check("R4", "rdata both strobes", rdata, 16'h0);
        @(negedge clk);
        idle();
        do_read(AW'(4), 1'b0);

        // Write attempt during reset must not land (R10).
        @(negedge clk);
        rst_n = 1'b0; addr = AW'(NB - 2); bhe_n = 1'b0; wdata = 16'hBEEF;
        wr_n = 1'b0; rd_n = 1'b1;
        #1;
        check("R10", "cs_n write in reset", {12'h0, cs_n}, 16'h000F);
        check("R10", "we_n write in reset", {12'h0, we_n}, 16'h000F);
        @(negedge clk);
        idle(); rst_n = 1'b1;
        do_read(AW'(NB - 2), 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule